// File: doc/BRIEF.md
# Posted Write and Read Buffer

This block sits between a processor's bus and main memory. It accepts processor stores into an in-order queue of pending writes, so the processor goes on at its own cycle rate and does not wait for memory. The queue drains to a memory-side write port. A write that opens a new page, or that follows an idle memory cycle, is issued as a full access and is held until memory acknowledges it. A write whose page matches the write retired in the cycle just before, while memory reports the page still open, is issued as a page-mode access and retires in that same cycle. A run of writes to one page therefore drains at one write per clock.

Reads take one level of buffering. The read address is captured and passed to memory only once the write queue is empty, so a read never overtakes a pending write. The returned word is latched in a single holding register and presented to the processor together with one even-parity bit per byte. The block does not check whether a read hits a location that still has a write in the queue. The memory controller resolves those conflicts.

Top module: `pwb_buffer`

## Requirements
- R1: After a synchronous active-low reset, `wr_empty`=1, `wr_full`=0, `mem_wr_req`=0, `mem_rd_req`=0 and `cpu_rd_valid`=0.
- R2: A store is accepted on a clock where `cpu_wr_valid`=1 and `wr_full`=0. `wr_full` is 1 while six writes are pending, and a store offered while `wr_full`=1 is discarded and never reaches memory. `wr_empty` is 1 exactly when no write is pending.
- R3: Every accepted write is presented on the memory write port exactly once, in the order it was accepted, with its address, data and 4-bit byte-enable unchanged. Writes are never merged.
- R4: A full access (`mem_wr_page`=0) holds `mem_wr_req` and the same address and data until the cycle in which `mem_wr_ack`=1. The entry retires in that cycle.
- R5: A pending head write whose page (address bits [31:11]) equals that of a write retired in the previous cycle is issued with `mem_wr_page`=1 if `mem_page_open`=1. It retires in that cycle without an acknowledge, so a same-page run drains one write per clock.
- R6: If the page differs, `mem_page_open`=0, or no write retired in the previous cycle, the head write is issued with `mem_wr_page`=0.
- R7: A captured read is forwarded on `mem_rd_req`, with `mem_rd_addr` equal to the captured address, only while `wr_empty`=1. With an empty queue it appears on the cycle after `cpu_rd_req`.
- R8: Data on `mem_rd_data` in a cycle with `mem_rd_req`=1 and `mem_rd_ack`=1 is latched. `cpu_rd_valid` pulses for exactly the next cycle, and `cpu_rd_data` keeps the word until the next read completes.
- R9: `cpu_rd_par[i]` is the XOR of bits [8i+7:8i] of `cpu_rd_data`, so that each byte together with its parity bit holds an even number of ones.
- R10: `cpu_rd_req` is ignored while a read is outstanding (`rd_busy`=1). The outstanding address is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_valid | input | 1 | Processor offers a store |
| cpu_wr_addr | input | 32 | Store address |
| cpu_wr_data | input | 32 | Store data |
| cpu_wr_be | input | 4 | Store byte enables |
| wr_full | output | 1 | Six writes pending; stores are refused |
| wr_empty | output | 1 | No write pending |
| cpu_rd_req | input | 1 | Processor starts a read |
| cpu_rd_addr | input | 32 | Read address |
| rd_busy | output | 1 | A read is outstanding |
| cpu_rd_valid | output | 1 | One-cycle pulse: read data ready |
| cpu_rd_data | output | 32 | Latched read data |
| cpu_rd_par | output | 4 | Even parity per byte of read data |
| mem_wr_req | output | 1 | Head write presented to memory |
| mem_wr_page | output | 1 | Write issued as page-mode access |
| mem_wr_addr | output | 32 | Write address to memory |
| mem_wr_data | output | 32 | Write data to memory |
| mem_wr_be | output | 4 | Write byte enables to memory |
| mem_wr_ack | input | 1 | Memory completes a full-access write |
| mem_page_open | input | 1 | Memory reports the last page still open |
| mem_rd_req | output | 1 | Read forwarded to memory |
| mem_rd_addr | output | 32 | Read address to memory |
| mem_rd_ack | input | 1 | Memory returns read data |
| mem_rd_data | input | 32 | Read data from memory |

## Verification
A store accepted at a clock edge is visible at the memory write port in the following cycle when the queue was empty. `wr_full` changes one edge after the sixth acceptance. A page-mode issue is due in the cycle right after a retirement. `cpu_rd_valid` and the parity bits are due one cycle after the read acknowledge, and a read is forwarded one cycle after its request when the queue is empty. The bench drives every input on the falling edge and samples 3 ns later, one nanosecond before the next rising edge. Each retirement it sees is compared against a scoreboard entry, and the expected page-mode flag is computed from the bench's own record of the previous cycle.

// File: rtl/pwb_pkg.sv
// Shared widths and the queued-write record for the posted write buffer.
// Assumes a 32-bit byte-addressed bus with one enable per byte.
package pwb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wr_entry_t;
endpackage

// File: rtl/pwb_wq.sv
// In-order write queue: a circular buffer of DEPTH entries with occupancy
// flags. Assumes the caller never pushes when full or pops when empty.
module pwb_wq
    import pwb_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t din,
    input  logic      pop,
    output wr_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    wr_entry_t        slot_q [DEPTH];
    logic [PW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    cnt_q;

    // Entry storage: written at the write pointer on each push.
    always_ff @(posedge clk) begin
        if (push) slot_q[wptr_q] <= din;
    end

    // Pointers and occupancy count, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Head view and flags.
    always_comb begin
        head  = slot_q[rptr_q];
        full  = (cnt_q == CW'(DEPTH));
        empty = (cnt_q == '0);
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/pwb_parity.sv
// Per-byte even parity generator: one bit per byte, set when that byte
// holds an odd number of ones. Purely combinational.
module pwb_parity #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] data,
    output logic [BYTES-1:0]   par
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        // Reduce one byte to its parity bit.
        always_comb par[b] = ^data[8*b +: 8];
    end
endmodule

// File: rtl/pwb_buffer.sv
// Posted write and read buffer. Queues processor stores and drains them in
// order, using page-mode issue when the head write shares the page of the
// write retired in the previous cycle. Holds one read and latches its data
// with byte parity. Assumes memory resolves read-after-write hazards itself.
module pwb_buffer
    import pwb_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int PAGE_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_valid,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic [BE_W-1:0]   cpu_wr_be,
    output logic              wr_full,
    output logic              wr_empty,
    input  logic              cpu_rd_req,
    input  logic [ADDR_W-1:0] cpu_rd_addr,
    output logic              rd_busy,
    output logic              cpu_rd_valid,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic [BE_W-1:0]   cpu_rd_par,
    output logic              mem_wr_req,
    output logic              mem_wr_page,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [BE_W-1:0]   mem_wr_be,
    input  logic              mem_wr_ack,
    input  logic              mem_page_open,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data
);
    localparam int PG_W = ADDR_W - PAGE_BITS;

    typedef enum logic {RD_IDLE, RD_WAIT} rd_state_e;

    wr_entry_t       in_ent, head;
    logic            accept, retire, pg_hit;
    logic [PG_W-1:0] head_pg, last_pg_q;
    logic            last_ret_q;
    rd_state_e       rd_st_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rd_data_q;
    logic            rd_valid_q;

    // Store acceptance and record packing.
    always_comb begin
        accept      = cpu_wr_valid && !wr_full;
        in_ent.addr = cpu_wr_addr;
        in_ent.data = cpu_wr_data;
        in_ent.be   = cpu_wr_be;
    end

    pwb_wq #(.DEPTH(DEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (in_ent),
        .pop   (retire),
        .head  (head),
        .full  (wr_full),
        .empty (wr_empty)
    );

    // Write issue: page-mode when following a same-page retirement.
    always_comb begin
        head_pg     = head.addr[ADDR_W-1:PAGE_BITS];
        pg_hit      = last_ret_q && (head_pg == last_pg_q) && mem_page_open;
        mem_wr_req  = !wr_empty;
        mem_wr_page = mem_wr_req && pg_hit;
        retire      = mem_wr_req && (pg_hit || mem_wr_ack);
        mem_wr_addr = head.addr;
        mem_wr_data = head.data;
        mem_wr_be   = head.be;
    end

    // Remember whether and in which page a write retired last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ret_q <= 1'b0;
            last_pg_q  <= '0;
        end else begin
            last_ret_q <= retire;
            if (retire) last_pg_q <= head_pg;
        end
    end

    // Single read holder: capture, forward when writes drained, latch data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_st_q    <= RD_IDLE;
            rd_addr_q  <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            case (rd_st_q)
                RD_IDLE: if (cpu_rd_req) begin
                    rd_addr_q <= cpu_rd_addr;
                    rd_st_q   <= RD_WAIT;
                end
                RD_WAIT: if (mem_rd_req && mem_rd_ack) begin
                    rd_data_q  <= mem_rd_data;
                    rd_valid_q <= 1'b1;
                    rd_st_q    <= RD_IDLE;
                end
                default: rd_st_q <= RD_IDLE;
            endcase
        end
    end

    // Read-side outputs.
    always_comb begin
        rd_busy      = (rd_st_q == RD_WAIT);
        mem_rd_req   = rd_busy && wr_empty;
        mem_rd_addr  = rd_addr_q;
        cpu_rd_valid = rd_valid_q;
        cpu_rd_data  = rd_data_q;
    end

    pwb_parity #(.BYTES(BE_W)) u_par (
        .data (rd_data_q),
        .par  (cpu_rd_par)
    );

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_page && !mem_wr_ack) |=>
        (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R5
    page_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_page |-> $past(retire));
    // R7
    rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !mem_wr_req);
    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_valid |-> $past(mem_rd_req && mem_rd_ack));
    // R10
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && $past(rd_busy)) |-> $stable(mem_rd_addr));
endmodule

// File: tb/pwb_buffer_tb.sv
module pwb_buffer_tb;
    localparam int PB = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_valid = 1'b0;
    logic [31:0] cpu_wr_addr = '0, cpu_wr_data = '0;
    logic [3:0]  cpu_wr_be = '0;
    logic        wr_full, wr_empty;
    logic        cpu_rd_req = 1'b0;
    logic [31:0] cpu_rd_addr = '0;
    logic        rd_busy, cpu_rd_valid;
    logic [31:0] cpu_rd_data;
    logic [3:0]  cpu_rd_par;
    logic        mem_wr_req, mem_wr_page;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        mem_wr_ack = 1'b0, mem_page_open = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int n_chk = 0, n_fail = 0;
    int ack_mode = 0;      // 0 never, 1 always, 2 after two waiting cycles
    int wcnt = 0;
    logic [67:0] exp_q [$];

    always #4 clk = ~clk;

    pwb_buffer u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [67:0] act, input logic [67:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [3:0] parity_of(input logic [31:0] d);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ($countones(d[8*b +: 8]) % 2) == 1;
        return p;
    endfunction

    // Driver: offers one store; queues it as expected only if not full.
    task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = be;
        if (!wr_full) exp_q.push_back({a, d, be});
    endtask

    task automatic wr_stop();
        @(negedge clk);
        cpu_wr_valid = 1'b0;
    endtask

    task automatic samp();
        @(negedge clk);
        #3;
    endtask

    task automatic rd_issue(input logic [31:0] a);
        @(negedge clk);
        cpu_rd_req = 1'b1; cpu_rd_addr = a;
        @(negedge clk);
        cpu_rd_req = 1'b0;
    endtask

    // Memory write-acknowledge model.
    always @(negedge clk) begin
        if (ack_mode == 1) mem_wr_ack = 1'b1;
        else if (ack_mode == 2) begin
            if (mem_wr_req && !mem_wr_page && !mem_wr_ack && wcnt >= 2) begin
                mem_wr_ack = 1'b1; wcnt = 0;
            end else begin
                mem_wr_ack = 1'b0;
                if (mem_wr_req && !mem_wr_page) wcnt++;
            end
        end else mem_wr_ack = 1'b0;
    end

    // Monitor: compares each retirement with the scoreboard.
    bit          prev_ret = 0;
    logic [20:0] prev_pg = '0;
    bit          hold_pend = 0;
    logic [31:0] hold_addr = '0;
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            bit ret, exp_pg;
            logic [67:0] e;
            ret = mem_wr_req && (mem_wr_page || mem_wr_ack);
            if (mem_wr_req) begin
                exp_pg = prev_ret && (mem_wr_addr[31:PB] == prev_pg) && mem_page_open;
                if (hold_pend)
                    chk(mem_wr_addr == hold_addr, "R4", "held address", mem_wr_addr, hold_addr);
                hold_pend = 0;
                chk(mem_wr_page == exp_pg, exp_pg ? "R5" : "R6", "page flag", mem_wr_page, exp_pg);
                if (ret) begin
                    if (exp_q.size() == 0)
                        chk(1'b0, "R2", "unexpected write", {mem_wr_addr, mem_wr_data, mem_wr_be}, 0);
                    else begin
                        e = exp_q.pop_front();
                        chk({mem_wr_addr, mem_wr_data, mem_wr_be} == e, "R3", "write order/content",
                            {mem_wr_addr, mem_wr_data, mem_wr_be}, e);
                    end
                end else begin
                    hold_pend = 1; hold_addr = mem_wr_addr;
                end
            end
            prev_ret = ret;
            if (ret) prev_pg = mem_wr_addr[31:PB];
        end
    end

    initial begin
        #(8 * 20000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 0);
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) samp();
        chk(wr_empty && !wr_full && !mem_wr_req && !mem_rd_req && !cpu_rd_valid, "R1", "reset state",
            {wr_empty, wr_full, mem_wr_req, mem_rd_req, cpu_rd_valid}, 5'b10000);
        @(negedge clk); rst_n = 1'b1;

        // R6: page closed, immediate acks, distinct pages
        ack_mode = 1; mem_page_open = 1'b0;
        push_wr(32'h0000_0100, 32'h1111_0001, 4'hF);
        push_wr(32'h0001_0000, 32'h2222_0002, 4'h3);
        push_wr(32'h0002_0000, 32'h3333_0003, 4'h8);
        wr_stop();
        repeat (5) samp();
        chk(wr_empty, "R2", "empty after drain", wr_empty, 1);

        // R2: fill to six, seventh refused; then R5 page-mode drain
        ack_mode = 0; mem_page_open = 1'b1;
        for (int i = 0; i < 7; i++) push_wr(32'h0000_1000 + 4 * i, 32'hA000_0000 + i, 4'(i + 1));
        wr_stop();
        samp();
        chk(wr_full, "R2", "full with six pending", wr_full, 1);
        chk(exp_q.size() == 6, "R2", "seventh store refused", exp_q.size(), 6);
        ack_mode = 2;
        repeat (15) samp();
        chk(wr_empty && exp_q.size() == 0, "R3", "all six drained", exp_q.size(), 0);

        // R5/R6: page change in the middle of a run
        for (int i = 0; i < 4; i++)
            push_wr((i < 2) ? 32'h0000_2000 + 4 * i : 32'h0000_4000 + 4 * i, 32'hB000_0000 + i, 4'hF);
        wr_stop();
        repeat (20) samp();
        chk(wr_empty && exp_q.size() == 0, "R3", "mixed pages drained", exp_q.size(), 0);

        // R7/R10: read waits behind writes; a second request is ignored
        ack_mode = 0;
        push_wr(32'h0000_3000, 32'hC000_0001, 4'hF);
        push_wr(32'h0000_3004, 32'hC000_0002, 4'hF);
        wr_stop();
        rd_issue(32'hABCD_0010);
        rd_issue(32'h5555_0020);
        samp();
        chk(!mem_rd_req && rd_busy, "R7", "read held behind writes", mem_rd_req, 0);
        ack_mode = 2;
        for (int i = 0; i < 40; i++) begin
            samp();
            if (mem_rd_req) break;
        end
        chk(mem_rd_req && wr_empty, "R7", "read forwarded after drain", {mem_rd_req, wr_empty}, 2'b11);
        chk(mem_rd_addr == 32'hABCD_0010, "R10", "first read address kept", mem_rd_addr, 32'hABCD_0010);
        @(negedge clk); mem_rd_data = 32'h0180_FF7E; mem_rd_ack = 1'b1;
        @(negedge clk); mem_rd_ack = 1'b0; #3;
        chk(cpu_rd_valid && cpu_rd_data == 32'h0180_FF7E, "R8", "read data valid", cpu_rd_data, 32'h0180_FF7E);
        chk(cpu_rd_par == parity_of(32'h0180_FF7E), "R9", "parity", cpu_rd_par, parity_of(32'h0180_FF7E));
        samp();
        chk(!cpu_rd_valid && cpu_rd_data == 32'h0180_FF7E, "R8", "one-cycle pulse, data held",
            {cpu_rd_valid, cpu_rd_data}, {1'b0, 32'h0180_FF7E});
        chk(!mem_rd_req && !rd_busy, "R10", "read retired", rd_busy, 0);

        // R7: empty queue forwards on the next cycle; R9 another pattern
        rd_issue(32'h0000_7777);
        #3;
        chk(mem_rd_req && mem_rd_addr == 32'h0000_7777, "R7", "immediate forward", mem_rd_addr, 32'h0000_7777);
        @(negedge clk); mem_rd_data = 32'hFFFF_0103; mem_rd_ack = 1'b1;
        @(negedge clk); mem_rd_ack = 1'b0; #3;
        chk(cpu_rd_valid && cpu_rd_data == 32'hFFFF_0103, "R8", "second read data", cpu_rd_data, 32'hFFFF_0103);
        chk(cpu_rd_par == parity_of(32'hFFFF_0103), "R9", "second parity", cpu_rd_par, parity_of(32'hFFFF_0103));

        chk(exp_q.size() == 0, "R3", "scoreboard empty at end", exp_q.size(), 0);
        summary();
    end
endmodule